// File: doc/BRIEF.md
# Debug Event Logger for Interrupt Entry and Interrupt Return

This block watches the exception and retirement side of a processor core for two debug events. An interrupt-taken event occurs when the core enters a noncritical interrupt. A return event occurs when a return-from-interrupt instruction executes. Each event is recorded in a small sticky status register. When the debug-enable machine-state bit is clear at the moment of logging, the register also records that the event was imprecise.

The block decides whether a debug interrupt is requested at once (precise delivery), later (delayed delivery), or not at all. A delayed request is issued when debug interrupts are turned back on while an unacknowledged event bit is still set. With each request the block presents the address the core must save in its critical save/restore register. For a precise interrupt-taken event this is the vector of the noncritical interrupt. For a precise return event it is the next instruction. For a delayed request it is the instruction after the one that re-enabled debug interrupts. Handler software clears status bits by writing ones.

Top module: `dbg_evt_logger`

## Requirements
- R1: When `en_irq_evt` is 1 and `nc_irq_take` pulses, status bit 0 (interrupt-taken) reads 1 after the next clock edge, whatever `msr_de` is. With `en_irq_evt` at 0 the strobe changes nothing.
- R2: Status bits are sticky. A cycle with `sts_clr_we` at 1 clears every bit whose `sts_clr_mask` bit is 1. A bit that a new event sets in the same cycle stays 1.
- R3: An event logged while `msr_de` is 0 also sets status bit 2 (imprecise) and raises no request in that cycle.
- R4: An interrupt-taken event with `msr_de` at 1 and `hi_prio_exc` at 0 gives `dbg_req`=1 after the next edge, with `dbg_addr` equal to `nc_irq_vec` and `dbg_delayed`=0. If `hi_prio_exc` is 1, the event is logged but no request is made.
- R5: When `en_ret_evt` is 1 and `rfi_exec` pulses, status bit 1 (return) is set. When `en_ret_evt` is 0 the strobe changes nothing.
- R6: A return event with `msr_de` at 1 requests a precise interrupt with `dbg_addr` equal to `ret_next_pc`. The request is withheld, though the event is still logged, when `ret_clears_de` or `hi_prio_exc` is 1.
- R7: For `rfci_exec` with return events enabled: when `msr_de` is 1 it behaves like a precise return event. When `msr_de` is 0 it sets no status bit and raises no request.
- R8: After an imprecise event, the first cycle in which `msr_de` is 1 and bit 0 or bit 1 is still set gives exactly one request, with `dbg_delayed`=1 and `dbg_addr` equal to `de_next_pc`. Later cycles give no further request for that condition.
- R9: Clearing bits 0 and 1 before `msr_de` returns to 1 cancels the delayed request.
- R10: `dbg_req` is high for only one cycle per delivery. It is never high unless `msr_de` was 1 in the cycle before, and `dbg_delayed` is only high together with `dbg_req`.
- R11: After reset, status, `dbg_req`, `dbg_delayed` and `dbg_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_irq_evt | input | 1 | Enable for interrupt-taken events |
| en_ret_evt | input | 1 | Enable for return events |
| msr_de | input | 1 | Debug-enable machine-state bit |
| hi_prio_exc | input | 1 | A higher-priority exception has taken the core this cycle |
| nc_irq_take | input | 1 | Strobe: noncritical interrupt entered |
| nc_irq_vec | input | AW | Vector address of that noncritical interrupt |
| rfi_exec | input | 1 | Strobe: normal return-from-interrupt executes |
| rfci_exec | input | 1 | Strobe: critical return-from-interrupt executes |
| ret_clears_de | input | 1 | The executing return leaves debug-enable at 0 |
| ret_next_pc | input | AW | Address of the instruction after the return |
| de_next_pc | input | AW | Address after the instruction that set debug-enable |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for the status |
| sts_clr_mask | input | 3 | Bits to clear (bit0 irq, bit1 return, bit2 imprecise) |
| sts | output | 3 | Sticky status: bit0 irq-taken, bit1 return, bit2 imprecise |
| dbg_req | output | 1 | One-cycle debug interrupt request |
| dbg_addr | output | AW | Address to save with the request |
| dbg_delayed | output | 1 | The request is a delayed delivery |

## Verification
Every result is registered once. Status and request outputs therefore show the effect of inputs sampled at a rising edge from just after that edge, and the request is gone one edge later. The bench drives inputs on the falling edge, lets one rising edge pass, and samples at the following falling edge. At that point it also checks that the pulse from the edge before has dropped. A delayed delivery is checked across several cycles: first in the cycle where debug-enable is still low, then in the cycle where it returns, then once more to confirm that it fires only once.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int STS_W   = 3;
  localparam int STS_IRQ = 0;
  localparam int STS_RET = 1;
  localparam int STS_IMP = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IRQ  = 2'd1,
    SRC_RET  = 2'd2,
    SRC_DLY  = 2'd3
  } req_src_e;
endpackage

// File: rtl/dbg_evt_detect.sv
module dbg_evt_detect (
  input  logic en_irq_evt,
  input  logic en_ret_evt,
  input  logic msr_de,
  input  logic hi_prio_exc,
  input  logic nc_irq_take,
  input  logic rfi_exec,
  input  logic rfci_exec,
  input  logic ret_clears_de,
  output logic log_irq,
  output logic log_ret,
  output logic log_imp,
  output logic prec_irq,
  output logic prec_ret
);
  always_comb begin
    log_irq  = en_irq_evt & nc_irq_take;
    // critical return only counts while debug-enable is on
    log_ret  = en_ret_evt & (rfi_exec | (rfci_exec & msr_de));
    log_imp  = (log_irq | log_ret) & ~msr_de;
    prec_irq = log_irq & msr_de & ~hi_prio_exc;
    prec_ret = log_ret & msr_de & ~hi_prio_exc & ~ret_clears_de;
  end
endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status
  import dbg_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             log_irq,
  input  logic             log_ret,
  input  logic             log_imp,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_mask,
  input  logic             take_any,
  output logic [STS_W-1:0] sts,
  output logic             armed,
  output logic             evt_live
);
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] sts_n;
  logic             armed_n;

  always_comb begin
    set_vec          = '0;
    set_vec[STS_IRQ] = log_irq;
    set_vec[STS_RET] = log_ret;
    set_vec[STS_IMP] = log_imp;
    sts_n    = (sts & ~(clr_we ? clr_mask : {STS_W{1'b0}})) | set_vec;
    evt_live = sts_n[STS_IRQ] | sts_n[STS_RET];
    if (!evt_live)      armed_n = 1'b0;
    else if (log_imp)   armed_n = 1'b1;
    else if (take_any)  armed_n = 1'b0;
    else                armed_n = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts   <= '0;
      armed <= 1'b0;
    end else begin
      sts   <= sts_n;
      armed <= armed_n;
    end
  end
endmodule

// File: rtl/dbg_evt_issue.sv
module dbg_evt_issue
  import dbg_evt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prec_irq,
  input  logic          prec_ret,
  input  logic          armed,
  input  logic          msr_de,
  input  logic          evt_live,
  input  logic [AW-1:0] nc_irq_vec,
  input  logic [AW-1:0] ret_next_pc,
  input  logic [AW-1:0] de_next_pc,
  output logic          take_any,
  output logic          dbg_req,
  output logic [AW-1:0] dbg_addr,
  output logic          dbg_delayed
);
  req_src_e      src;
  logic [AW-1:0] addr_n;

  always_comb begin
    if (prec_irq)                        src = SRC_IRQ;
    else if (prec_ret)                   src = SRC_RET;
    else if (armed & msr_de & evt_live)  src = SRC_DLY;
    else                                 src = SRC_NONE;
    take_any = (src != SRC_NONE);
    unique case (src)
      SRC_IRQ: addr_n = nc_irq_vec;
      SRC_RET: addr_n = ret_next_pc;
      SRC_DLY: addr_n = de_next_pc;
      default: addr_n = dbg_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_req     <= 1'b0;
      dbg_delayed <= 1'b0;
    end else begin
      dbg_req     <= take_any;
      dbg_delayed <= (src == SRC_DLY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dbg_addr <= '0;
    else if (take_any) dbg_addr <= addr_n;
  end
endmodule

// File: rtl/dbg_evt_logger.sv
module dbg_evt_logger
  import dbg_evt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_irq_evt,
  input  logic             en_ret_evt,
  input  logic             msr_de,
  input  logic             hi_prio_exc,
  input  logic             nc_irq_take,
  input  logic [AW-1:0]    nc_irq_vec,
  input  logic             rfi_exec,
  input  logic             rfci_exec,
  input  logic             ret_clears_de,
  input  logic [AW-1:0]    ret_next_pc,
  input  logic [AW-1:0]    de_next_pc,
  input  logic             sts_clr_we,
  input  logic [STS_W-1:0] sts_clr_mask,
  output logic [STS_W-1:0] sts,
  output logic             dbg_req,
  output logic [AW-1:0]    dbg_addr,
  output logic             dbg_delayed
);
  logic log_irq, log_ret, log_imp, prec_irq, prec_ret;
  logic take_any, armed, evt_live;

  dbg_evt_detect u_detect (
    .en_irq_evt    (en_irq_evt),
    .en_ret_evt    (en_ret_evt),
    .msr_de        (msr_de),
    .hi_prio_exc   (hi_prio_exc),
    .nc_irq_take   (nc_irq_take),
    .rfi_exec      (rfi_exec),
    .rfci_exec     (rfci_exec),
    .ret_clears_de (ret_clears_de),
    .log_irq       (log_irq),
    .log_ret       (log_ret),
    .log_imp       (log_imp),
    .prec_irq      (prec_irq),
    .prec_ret      (prec_ret)
  );

  dbg_evt_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .log_irq  (log_irq),
    .log_ret  (log_ret),
    .log_imp  (log_imp),
    .clr_we   (sts_clr_we),
    .clr_mask (sts_clr_mask),
    .take_any (take_any),
    .sts      (sts),
    .armed    (armed),
    .evt_live (evt_live)
  );

  dbg_evt_issue #(.AW(AW)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .prec_irq    (prec_irq),
    .prec_ret    (prec_ret),
    .armed       (armed),
    .msr_de      (msr_de),
    .evt_live    (evt_live),
    .nc_irq_vec  (nc_irq_vec),
    .ret_next_pc (ret_next_pc),
    .de_next_pc  (de_next_pc),
    .take_any    (take_any),
    .dbg_req     (dbg_req),
    .dbg_addr    (dbg_addr),
    .dbg_delayed (dbg_delayed)
  );
endmodule

// File: rtl/dbg_evt_logger_chk.sv
module dbg_evt_logger_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       msr_de,
  input logic       nc_irq_take,
  input logic       rfi_exec,
  input logic       rfci_exec,
  input logic       sts_clr_we,
  input logic [2:0] sts,
  input logic       dbg_req,
  input logic       dbg_delayed
);
  // R10: a request needs debug-enable high in the cycle it was decided
  a_r10_req_needs_de: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> $past(msr_de));

  // R10: the delayed flag only travels with a request
  a_r10_delayed_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_delayed |-> dbg_req);

  // R2: without a clear write no status bit drops
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sts_clr_we) |-> ((~sts & $past(sts)) == 3'b000));

  // R7: critical return with debug-enable low leaves everything alone
  a_r7_rfci_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rfci_exec) && !$past(msr_de) && !$past(nc_irq_take) &&
     !$past(rfi_exec) && !$past(sts_clr_we)) |-> (sts == $past(sts) && !dbg_req));

  // R8: a delayed delivery needs a pending event bit
  a_r8_delayed_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && dbg_delayed) |-> ($past(sts[1:0]) != 2'b00));
endmodule

bind dbg_evt_logger dbg_evt_logger_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msr_de      (msr_de),
  .nc_irq_take (nc_irq_take),
  .rfi_exec    (rfi_exec),
  .rfci_exec   (rfci_exec),
  .sts_clr_we  (sts_clr_we),
  .sts         (sts),
  .dbg_req     (dbg_req),
  .dbg_delayed (dbg_delayed)
);

// File: tb/dbg_evt_logger_test.sv
module dbg_evt_logger_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          en_irq_evt, en_ret_evt, msr_de, hi_prio_exc;
  logic          nc_irq_take, rfi_exec, rfci_exec, ret_clears_de;
  logic [AW-1:0] nc_irq_vec, ret_next_pc, de_next_pc;
  logic          sts_clr_we;
  logic [2:0]    sts_clr_mask;
  logic [2:0]    sts;
  logic          dbg_req, dbg_delayed;
  logic [AW-1:0] dbg_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dbg_evt_logger #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .en_irq_evt(en_irq_evt), .en_ret_evt(en_ret_evt),
    .msr_de(msr_de), .hi_prio_exc(hi_prio_exc), .nc_irq_take(nc_irq_take),
    .nc_irq_vec(nc_irq_vec), .rfi_exec(rfi_exec), .rfci_exec(rfci_exec),
    .ret_clears_de(ret_clears_de), .ret_next_pc(ret_next_pc), .de_next_pc(de_next_pc),
    .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask), .sts(sts),
    .dbg_req(dbg_req), .dbg_addr(dbg_addr), .dbg_delayed(dbg_delayed)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // called at a falling edge: one rising edge passes, back at a falling edge
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    nc_irq_take = 0; rfi_exec = 0; rfci_exec = 0; ret_clears_de = 0;
    hi_prio_exc = 0; sts_clr_we = 0; sts_clr_mask = 3'b000;
  endtask

  task automatic clear_all();
    sts_clr_we = 1; sts_clr_mask = 3'b111;
    cyc();
    idle_inputs();
    chk("R2 clear all", {29'd0, sts}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R11 sts", {29'd0, sts}, 32'd0);
    chk("R11 req", {31'd0, dbg_req}, 32'd0);
    chk("R11 dly", {31'd0, dbg_delayed}, 32'd0);
    chk("R11 addr", dbg_addr, 32'd0);
  endtask

  task automatic t_irq_disabled();
    en_irq_evt = 0; msr_de = 1; nc_irq_take = 1; nc_irq_vec = 32'h700;
    cyc(); idle_inputs();
    chk("R1 disabled sts", {29'd0, sts}, 32'd0);
    chk("R1 disabled req", {31'd0, dbg_req}, 32'd0);
    en_irq_evt = 1;
  endtask

  task automatic t_irq_precise();
    msr_de = 1; nc_irq_take = 1; nc_irq_vec = 32'h500;
    cyc(); idle_inputs();
    chk("R1 sts", {29'd0, sts}, 32'b001);
    chk("R4 req", {31'd0, dbg_req}, 32'd1);
    chk("R4 addr", dbg_addr, 32'h500);
    chk("R4 dly", {31'd0, dbg_delayed}, 32'd0);
    cyc();
    chk("R10 pulse drops", {31'd0, dbg_req}, 32'd0);
    chk("R2 sticky", {29'd0, sts}, 32'b001);
    sts_clr_we = 1; sts_clr_mask = 3'b001;
    cyc(); idle_inputs();
    chk("R2 w1c", {29'd0, sts}, 32'd0);
  endtask

  task automatic t_hi_prio();
    msr_de = 1; hi_prio_exc = 1; nc_irq_take = 1; nc_irq_vec = 32'h900;
    cyc(); idle_inputs();
    chk("R4 hp logged", {29'd0, sts}, 32'b001);
    chk("R4 hp no req", {31'd0, dbg_req}, 32'd0);
    clear_all();
  endtask

  task automatic t_delayed();
    msr_de = 0; nc_irq_take = 1; nc_irq_vec = 32'h800;
    cyc(); idle_inputs();
    chk("R3 imp sts", {29'd0, sts}, 32'b101);
    chk("R3 no req", {31'd0, dbg_req}, 32'd0);
    cyc();
    chk("R3 still no req", {31'd0, dbg_req}, 32'd0);
    msr_de = 1; de_next_pc = 32'h1234;
    cyc();
    chk("R8 req", {31'd0, dbg_req}, 32'd1);
    chk("R8 dly", {31'd0, dbg_delayed}, 32'd1);
    chk("R8 addr", dbg_addr, 32'h1234);
    cyc();
    chk("R8 once", {31'd0, dbg_req}, 32'd0);
    cyc();
    chk("R8 once later", {31'd0, dbg_req}, 32'd0);
    clear_all();
  endtask

  task automatic t_cancel();
    msr_de = 0; en_ret_evt = 1; rfi_exec = 1; ret_next_pc = 32'h40;
    cyc(); idle_inputs();
    chk("R5 imp ret sts", {29'd0, sts}, 32'b110);
    sts_clr_we = 1; sts_clr_mask = 3'b010;
    cyc(); idle_inputs();
    chk("R9 partial clear", {29'd0, sts}, 32'b100);
    msr_de = 1; de_next_pc = 32'h55;
    cyc();
    chk("R9 no delayed req", {31'd0, dbg_req}, 32'd0);
    clear_all();
  endtask

  task automatic t_set_wins();
    msr_de = 0; nc_irq_take = 1; nc_irq_vec = 32'h600;
    sts_clr_we = 1; sts_clr_mask = 3'b001;
    cyc(); idle_inputs();
    chk("R2 set beats clear", {29'd0, sts}, 32'b101);
    clear_all();
    msr_de = 1;
    cyc();
    chk("R9 cleared no req", {31'd0, dbg_req}, 32'd0);
  endtask

  task automatic t_ret();
    en_ret_evt = 0; msr_de = 1; rfi_exec = 1; ret_next_pc = 32'h2000;
    cyc(); idle_inputs();
    chk("R5 disabled", {29'd0, sts}, 32'd0);
    en_ret_evt = 1; rfi_exec = 1;
    cyc(); idle_inputs();
    chk("R5 sts", {29'd0, sts}, 32'b010);
    chk("R6 req", {31'd0, dbg_req}, 32'd1);
    chk("R6 addr", dbg_addr, 32'h2000);
    clear_all();
    rfi_exec = 1; ret_clears_de = 1; ret_next_pc = 32'h2100;
    cyc(); idle_inputs();
    chk("R6 clears de logged", {29'd0, sts}, 32'b010);
    chk("R6 clears de no req", {31'd0, dbg_req}, 32'd0);
    clear_all();
  endtask

  task automatic t_rfci();
    msr_de = 0; rfci_exec = 1; ret_next_pc = 32'h3100;
    cyc(); idle_inputs();
    chk("R7 de0 sts", {29'd0, sts}, 32'd0);
    chk("R7 de0 req", {31'd0, dbg_req}, 32'd0);
    msr_de = 1; rfci_exec = 1; ret_next_pc = 32'h3000;
    cyc(); idle_inputs();
    chk("R7 de1 sts", {29'd0, sts}, 32'b010);
    chk("R7 de1 req", {31'd0, dbg_req}, 32'd1);
    chk("R7 de1 addr", dbg_addr, 32'h3000);
    clear_all();
  endtask

  initial begin
    rst_n = 0; en_irq_evt = 0; en_ret_evt = 0; msr_de = 0;
    nc_irq_vec = '0; ret_next_pc = '0; de_next_pc = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    t_reset();
    t_irq_disabled();
    t_irq_precise();
    t_hi_prio();
    t_delayed();
    t_cancel();
    t_set_wins();
    t_ret();
    t_rfci();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule